// File: doc/BRIEF.md
# Serial-loaded eight-channel code register bank

This block receives addressed writes on a three-wire serial port and keeps eight 8-bit output codes, each of which drives one trim channel. A frame is framed by an active-low select line. While select is low, each rising edge of the serial clock shifts one data bit into an 11-bit capture register. The first three bits received form the channel address and the last eight bits form the code. When select goes high again, the code is written into the addressed channel. The write only happens if the frame had exactly eleven clock edges.

The serial pins are not tied to any clock. They pass through two-flop synchronizers into the system clock, and their edges are detected in that domain. An asynchronous active-low reset loads every channel with the midscale code 0x80. An active-low shutdown input drives every parallel output to zero. During shutdown the stored codes are kept and can still be written, and they reappear on the outputs when shutdown is released.

Top module: `trim_code_bank`

## Requirements
- R1: While reset is asserted and after it is released, every channel output reads 0x80 if shutdown is not asserted.
- R2: Bits arrive most significant first. Address bit 2 comes first, then address bits 1 and 0, then code bit 7, and code bit 0 comes last.
- R3: A frame with exactly 11 rising serial-clock edges while select is low writes its code into the addressed channel when select rises. No other channel changes.
- R4: A frame with fewer than 11 rising edges is discarded, and every channel keeps its code.
- R5: A frame with more than 11 rising edges is discarded, and every channel keeps its code.
- R6: While shutdown is low, every channel output reads 0x00 from the next system clock onward.
- R7: Releasing shutdown restores the codes held before shutdown on the outputs.
- R8: Frames received during shutdown update the stored codes, and those codes appear when shutdown is released.
- R9: Channel k drives bits [8k+7:8k] of the flat output bus.
- R10: Asserting reset after writes returns every channel to 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, presets channels to midscale |
| sclk | input | 1 | Serial clock, sampled on rising edges |
| sdi | input | 1 | Serial data, most significant bit first |
| cs_n | input | 1 | Active-low frame select, a rising edge ends the frame |
| shdn_n | input | 1 | Active-low shutdown, zeroes the outputs |
| ch_code_o | output | 64 | Eight 8-bit channel codes, channel k at [8k+7:8k] |

## Verification
The checker watches four rules on every cycle. The stored codes never change without a write pulse. A write pulse lasts exactly one cycle. A write lands the captured code in the addressed channel on the next cycle. The outputs read zero while shutdown is held, and they return to the stored codes right after it is released. Other behaviour shows only in the bench scenarios: the bit order of the frame, rejecting frames whose edge count is wrong, writes made during shutdown, the midscale preset, and that only the addressed channel changes. In these scenarios a scoreboard compares the whole output bus against a reference model after every frame.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
    localparam int NUM_CH_DEF  = 8;
    localparam int CODE_W_DEF  = 8;
    localparam int SYNC_DEF    = 2;

    // the three serial pins, carried together through the synchronizer
    typedef struct packed {
        logic sclk;
        logic sdi;
        logic cs_n;
    } serial_pins_t;

    localparam serial_pins_t PINS_IDLE = '{sclk: 1'b0, sdi: 1'b0, cs_n: 1'b1};
endpackage

// File: rtl/tcb_sync.sv
module tcb_sync
    import tcb_pkg::*;
#(
    parameter int STAGES = SYNC_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  serial_pins_t pins_i,
    output serial_pins_t pins_o
);
    serial_pins_t [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pins_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{PINS_IDLE}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign pins_o = chain_q[STAGES-1];
endmodule

// File: rtl/tcb_frame_rx.sv
module tcb_frame_rx
    import tcb_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  serial_pins_t      pins_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [CODE_W-1:0] wr_code_o
);
    localparam int FRAME_W = ADDR_W + CODE_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic               sclk_prev;
        logic               cs_prev;
        logic [FRAME_W-1:0] shift;
        logic [CNT_W-1:0]   cnt;
        logic               wr_en;
        logic [ADDR_W-1:0]  addr;
        logic [CODE_W-1:0]  code;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic sclk_rise, cs_rise, cs_fall;

    always_comb begin
        sclk_rise = pins_i.sclk & ~st_q.sclk_prev;
        cs_rise   = pins_i.cs_n & ~st_q.cs_prev;
        cs_fall   = ~pins_i.cs_n & st_q.cs_prev;

        st_d           = st_q;
        st_d.wr_en     = 1'b0;
        st_d.sclk_prev = pins_i.sclk;
        st_d.cs_prev   = pins_i.cs_n;

        if (cs_fall) begin
            st_d.cnt = '0;
        end else if (!pins_i.cs_n && sclk_rise) begin
            st_d.shift = {st_q.shift[FRAME_W-2:0], pins_i.sdi};
            if (st_q.cnt != CNT_SAT) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (cs_rise) begin
            if (st_q.cnt == CNT_FULL) begin
                st_d.wr_en = 1'b1;
                st_d.addr  = st_q.shift[FRAME_W-1 -: ADDR_W];
                st_d.code  = st_q.shift[CODE_W-1:0];
            end
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sclk_prev: 1'b0, cs_prev: 1'b1, shift: '0, cnt: '0,
                      wr_en: 1'b0, addr: '0, code: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o   = st_q.wr_en;
    assign wr_addr_o = st_q.addr;
    assign wr_code_o = st_q.code;
endmodule

// File: rtl/tcb_reg_file.sv
module tcb_reg_file #(
    parameter int                NUM_CH     = 8,
    parameter int                CODE_W     = 8,
    parameter int                ADDR_W     = $clog2(NUM_CH),
    parameter logic [CODE_W-1:0] RESET_CODE = CODE_W'(1) << (CODE_W - 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [CODE_W-1:0]        wr_code_i,
    output logic [NUM_CH*CODE_W-1:0] regs_o
);
    logic [NUM_CH-1:0][CODE_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i && (int'(wr_addr_i) < NUM_CH)) begin
            regs_d[wr_addr_i] = wr_code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= {NUM_CH{RESET_CODE}};
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_flat
        assign regs_o[k*CODE_W +: CODE_W] = regs_q[k];
    end
endmodule

// File: rtl/trim_code_bank.sv
module trim_code_bank
    import tcb_pkg::*;
#(
    parameter int NUM_CH      = NUM_CH_DEF,
    parameter int CODE_W      = CODE_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk,
    input  logic                     sdi,
    input  logic                     cs_n,
    input  logic                     shdn_n,
    output logic [NUM_CH*CODE_W-1:0] ch_code_o
);
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int BUS_W  = NUM_CH * CODE_W;
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    serial_pins_t        pins_raw, pins_sync;
    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [CODE_W-1:0]   wr_code;
    logic [BUS_W-1:0]    regs_flat;
    logic [BUS_W-1:0]    out_d, out_q;

    assign pins_raw = '{sclk: sclk, sdi: sdi, cs_n: cs_n};

    tcb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_raw),
        .pins_o (pins_sync)
    );

    tcb_frame_rx #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_i    (pins_sync),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_code_o (wr_code)
    );

    tcb_reg_file #(
        .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .RESET_CODE(MID_CODE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_code_i (wr_code),
        .regs_o    (regs_flat)
    );

    // shutdown gates the registered output bus, stored codes stay intact
    always_comb begin
        out_d = shdn_n ? regs_flat : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= {NUM_CH{MID_CODE}};
        end else begin
            out_q <= out_d;
        end
    end

    assign ch_code_o = out_q;
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 8,
    parameter int ADDR_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     shdn_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [CODE_W-1:0]        wr_code,
    input logic [NUM_CH*CODE_W-1:0] regs_flat,
    input logic [NUM_CH*CODE_W-1:0] ch_code_o
);
    logic [ADDR_W-1:0] addr_seen;
    logic [CODE_W-1:0] code_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_seen <= '0;
            code_seen <= '0;
        end else begin
            addr_seen <= wr_addr;
            code_seen <= wr_code;
        end
    end

    // R4 / R5: stored codes only move on a write pulse
    assert_stable_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));

    // R3: a write pulse lasts one cycle
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R3: the captured code lands in the addressed channel
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs_flat[addr_seen*CODE_W +: CODE_W] == code_seen));

    // R6: shutdown zeroes the bus
    assert_shutdown_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> (ch_code_o == '0));

    // R7: release puts the stored codes back
    assert_release_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shdn_n) |=> (ch_code_o == $past(regs_flat)));
endmodule

bind trim_code_bank tcb_checker #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shdn_n    (shdn_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_code   (wr_code),
    .regs_flat (regs_flat),
    .ch_code_o (ch_code_o)
);

// File: tb/tb_trim_code_bank.sv
module tb_trim_code_bank;
    localparam int NCH = 8;
    localparam int CW  = 8;
    localparam int HALF = 4;   // system clocks per serial half period

    typedef struct {
        logic [NCH*CW-1:0] val;
        string             tag;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic cs_n = 1'b1;
    logic shdn_n = 1'b1;
    logic [NCH*CW-1:0] ch_code_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [CW-1:0] model [NCH];
    exp_item_t sb_q[$];

    always #5 clk = ~clk;

    trim_code_bank dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi),
        .cs_n(cs_n), .shdn_n(shdn_n), .ch_code_o(ch_code_o)
    );

    function automatic logic [NCH*CW-1:0] expected_bus();
        logic [NCH*CW-1:0] v;
        for (int k = 0; k < NCH; k++) v[k*CW +: CW] = shdn_n ? model[k] : '0;
        return v;
    endfunction

    task automatic push_expect(string tag);
        exp_item_t it;
        it.val = expected_bus();
        it.tag = tag;
        sb_q.push_back(it);
        repeat (2) @(negedge clk);
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    // shift nbits out, MSB of {addr,code} first; bits past 11 are ones
    task automatic send_frame(int nbits, logic [2:0] addr, logic [CW-1:0] code);
        logic [10:0] word;
        word = {addr, code};
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 11) ? word[10-i] : 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        settle();
        if (nbits == 11) model[addr] = code;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int k = 0; k < NCH; k++) model[k] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // monitor: pops expected items and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (ch_code_o !== it.val) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, ch_code_o, it.val);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NCH; k++) model[k] = 8'h80;
        repeat (3) @(negedge clk);
        push_expect("R1 during reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        push_expect("R1 after reset");

        // R9: channel 5 lands on bits [47:40]
        send_frame(11, 3'd5, 8'h3C);
        push_expect("R9 layout ch5");
        // R2: bit order, asymmetric address and code
        send_frame(11, 3'b110, 8'h01);
        push_expect("R2 addr 6 code 01");
        send_frame(11, 3'b011, 8'hFE);
        push_expect("R2 addr 3 code FE");
        send_frame(11, 3'b001, 8'h80);
        push_expect("R2 addr 1 code 80");

        // R3: random writes, only addressed channel changes
        for (int n = 0; n < 16; n++) begin
            send_frame(11, 3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)));
            push_expect("R3 random write");
        end

        // R4: short frames discarded
        send_frame(10, 3'd2, 8'h55);
        push_expect("R4 ten edges");
        send_frame(1, 3'd7, 8'hAA);
        push_expect("R4 one edge");
        // R5: long frame discarded
        send_frame(12, 3'd4, 8'h11);
        push_expect("R5 twelve edges");

        // R6 / R7 / R8: shutdown behaviour
        @(negedge clk);
        shdn_n = 1'b0;
        @(negedge clk);
        push_expect("R6 shutdown zeroes");
        send_frame(11, 3'd0, 8'hC3);
        push_expect("R8 write in shutdown stays hidden");
        @(negedge clk);
        shdn_n = 1'b1;
        @(negedge clk);
        push_expect("R7 R8 release restores");

        // R10: reset after writes
        apply_reset();
        push_expect("R10 reset returns midscale");
        send_frame(11, 3'd7, 8'h42);
        push_expect("R3 write after reset");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule